// File: doc/BRIEF.md
# Replaying Request Queue with Issue Pacing

This block is a generic processing unit front end. An upstream producer hands it requests over a valid/accept handshake. Each request is a tracking ID plus a data word. The block holds a number of them in a circular store. It issues them strictly in arrival order to an execution block that sits outside the block. Issue is fire-and-forget: the execution block gets no back-pressure path. Instead, a countdown counter spaces issues by a run-time latency value. A hold input stretches the current execution by one cycle for every cycle it is high, which covers cases such as error correction.

Each stored entry stays in its slot until the execution side confirms that the oldest unconfirmed request is complete. Entries never move between slots. Three positions are tracked:
- a write position,
- an issue position,
- a retire position.

When the execution side reports a failure with a one-cycle replay pulse, the issue position jumps back to the retire position. The counter is cleared, and the unconfirmed requests go out again in their original order. Room for new requests is measured from the write position to the retire position. A request that has been issued therefore still occupies space until it is confirmed. The depth parameter must be a power of two.

Top module: `replay_issue_queue`

## Requirements
- R1: After reset `in_accept` is 1 and `iss_valid` is 0.
- R2: `in_accept` is 0 exactly when DEPTH requests are held between the write position and the retire position. A request presented while `in_accept` is 0 is not stored, and the sender must present it again.
- R3: Requests are issued in the order they were accepted, with `iss_id` and `iss_data` equal to the `in_id` and `in_data` they were accepted with.
- R4: `lat_cfg` is a 4-bit unsigned latency L, where the value 0 counts as 1. After an issue, the next issue comes no earlier than L cycles later. It comes exactly L cycles later when a pending request is waiting and no hold or replay intervenes. L is sampled in the issue cycle.
- R5: Each cycle in which `ecc_hold` is 1 while the latency countdown is still running delays the next allowed issue by one cycle. `ecc_hold` has no effect once the countdown has finished.
- R6: In a cycle with `exec_replay` = 1 nothing is issued. From the next cycle on, the oldest unconfirmed request and all later ones are issued again in order, with no latency wait before the first of them.
- R7: `exec_done` = 1 retires the oldest issued but unconfirmed request and frees its slot. `exec_done` while no request is issued and unconfirmed has no effect.
- R8: An issued request keeps its slot until it is retired, so the block can refuse new requests with nothing left to issue.
- R9: `iss_valid` is 1 only while an accepted request has not yet been issued since the last replay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Producer offers a request |
| in_id | input | ID_W | Tracking ID of the offered request |
| in_data | input | DATA_W | Payload of the offered request |
| in_accept | output | 1 | Block takes the offered request this cycle |
| lat_cfg | input | LAT_W | Execution latency in cycles (0 counts as 1) |
| ecc_hold | input | 1 | Stretch the running execution by one cycle |
| iss_valid | output | 1 | A request is issued this cycle |
| iss_id | output | ID_W | Tracking ID of the issued request |
| iss_data | output | DATA_W | Payload of the issued request |
| exec_done | input | 1 | Oldest unconfirmed request has completed |
| exec_replay | input | 1 | Execution failed; restart from the oldest unconfirmed request |

## Verification
The hardest situation to reach from the ports is a replay that lands while several requests are issued but unconfirmed, the latency countdown is still running, and a completion arrives in the same cycle. Directed phases handle the simpler cases: a latency sweep over all sixteen settings, hold pulses placed at each offset inside a countdown, a full queue with every entry issued, and a replay after three unconfirmed issues. A long pseudo-random phase then toggles push, hold, completion, replay and latency together, so that these coincidences occur many times. In every cycle a bench-side model of the three positions and the release cycle predicts the accept, issue, ID and data outputs.

// File: rtl/riq_pkg.sv
package riq_pkg;

  // Effective issue spacing for a latency setting: zero behaves as one.
  function automatic int unsigned pace_gap(input int unsigned lat);
    return (lat == 0) ? 1 : lat;
  endfunction

  // Value loaded into the countdown on issue so that the next issue is
  // allowed exactly pace_gap cycles later.
  function automatic int unsigned pace_load(input int unsigned lat);
    return pace_gap(lat) - 1;
  endfunction

endpackage

// File: rtl/riq_store.sv
module riq_store #(
  parameter int DEPTH = 8,
  parameter int W     = 20,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [W-1:0]     wr_word,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [W-1:0]     rd_word
);

  // Each slot is written once on push and read in place on every (re)issue.
  logic [W-1:0] slots [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_idx] <= wr_word;
  end

  assign rd_word = slots[rd_idx];

endmodule

// File: rtl/riq_ptrs.sv
module riq_ptrs #(
  parameter int DEPTH = 8,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int PTR_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             issue,
  input  logic             done,
  input  logic             replay,
  output logic [IDX_W-1:0] wr_idx,
  output logic [IDX_W-1:0] rd_idx,
  output logic             full,
  output logic             pending,
  output logic             retire
);

  logic [PTR_W-1:0] wr_ptr, rd_ptr, sav_ptr;
  logic [PTR_W-1:0] wr_nxt, rd_nxt, sav_nxt;
  logic             outstanding;

  function automatic logic [PTR_W-1:0] span(input logic [PTR_W-1:0] head,
                                            input logic [PTR_W-1:0] tail);
    return head - tail;
  endfunction

  assign full        = (span(wr_ptr, sav_ptr) == PTR_W'(DEPTH));
  assign pending     = (rd_ptr != wr_ptr);
  assign outstanding = (rd_ptr != sav_ptr);
  assign retire      = done && outstanding;

  assign wr_nxt  = wr_ptr + PTR_W'(push);
  assign sav_nxt = sav_ptr + PTR_W'(retire);
  assign rd_nxt  = replay ? sav_nxt : (rd_ptr + PTR_W'(issue));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      sav_ptr <= '0;
    end else begin
      wr_ptr  <= wr_nxt;
      rd_ptr  <= rd_nxt;
      sav_ptr <= sav_nxt;
    end
  end

  assign wr_idx = wr_ptr[IDX_W-1:0];
  assign rd_idx = rd_ptr[IDX_W-1:0];

  p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (span(wr_ptr, sav_ptr) < PTR_W'(DEPTH)));

  p_issue_has_work_r9: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> (span(wr_ptr, rd_ptr) != '0));

  p_replay_rewind_r6: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (rd_ptr == sav_ptr));

  p_retire_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    span(rd_ptr, sav_ptr) <= span(wr_ptr, sav_ptr));

endmodule

// File: rtl/riq_pacer.sv
module riq_pacer #(
  parameter int LAT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue,
  input  logic             replay,
  input  logic             hold,
  input  logic [LAT_W-1:0] lat,
  output logic             ready
);

  logic [LAT_W-1:0] cnt;
  logic [LAT_W-1:0] load_val;

  assign load_val = LAT_W'(riq_pkg::pace_load(32'(lat)));
  assign ready    = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (issue) begin
      cnt <= load_val;
    end else if (replay) begin
      cnt <= '0;
    end else if (!ready && !hold) begin
      cnt <= cnt - LAT_W'(1);
    end
  end

  p_quiet_after_issue_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (issue && (lat > LAT_W'(1))) |=> !ready);

  p_hold_freezes_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ready && hold && !issue && !replay) |=> (cnt == $past(cnt)));

  p_replay_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (replay && !issue) |=> ready);

endmodule

// File: rtl/replay_issue_queue.sv
module replay_issue_queue #(
  parameter int DEPTH  = 8,
  parameter int ID_W   = 4,
  parameter int DATA_W = 16,
  parameter int LAT_W  = 4,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int WORD_W = ID_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ID_W-1:0]   in_id,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_accept,
  input  logic [LAT_W-1:0]  lat_cfg,
  input  logic              ecc_hold,
  output logic              iss_valid,
  output logic [ID_W-1:0]   iss_id,
  output logic [DATA_W-1:0] iss_data,
  input  logic              exec_done,
  input  logic              exec_replay
);

  // Named internal events
  logic             push_ev;
  logic             issue_ev;
  logic             retire_ev;
  logic             q_full;
  logic             q_pending;
  logic             pace_ready;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [WORD_W-1:0] rd_word;

  assign in_accept = !q_full;
  assign push_ev   = in_valid && in_accept;
  assign issue_ev  = q_pending && pace_ready && !exec_replay;
  assign iss_valid = issue_ev;
  assign iss_id    = rd_word[WORD_W-1 -: ID_W];
  assign iss_data  = rd_word[DATA_W-1:0];

  riq_ptrs #(.DEPTH(DEPTH)) u_ptrs (
    .clk     (clk),
    .rst_n   (rst_n),
    .push    (push_ev),
    .issue   (issue_ev),
    .done    (exec_done),
    .replay  (exec_replay),
    .wr_idx  (wr_idx),
    .rd_idx  (rd_idx),
    .full    (q_full),
    .pending (q_pending),
    .retire  (retire_ev)
  );

  riq_store #(.DEPTH(DEPTH), .W(WORD_W)) u_store (
    .clk     (clk),
    .wr_en   (push_ev),
    .wr_idx  (wr_idx),
    .wr_word ({in_id, in_data}),
    .rd_idx  (rd_idx),
    .rd_word (rd_word)
  );

  riq_pacer #(.LAT_W(LAT_W)) u_pacer (
    .clk    (clk),
    .rst_n  (rst_n),
    .issue  (issue_ev),
    .replay (exec_replay),
    .hold   (ecc_hold),
    .lat    (lat_cfg),
    .ready  (pace_ready)
  );

  p_silent_on_replay_r6: assert property (@(posedge clk) disable iff (!rst_n)
    exec_replay |-> !iss_valid);

  p_refuse_when_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_accept && !retire_ev) |=> !in_accept);

endmodule

// File: tb/replay_issue_queue_test.sv
module replay_issue_queue_test;
  localparam int DEPTH = 8, ID_W = 4, DW = 16, LW = 4, MEMN = 8192;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, ecc_hold = 0, exec_done = 0, exec_replay = 0;
  logic [ID_W-1:0] in_id = '0;
  logic [DW-1:0]   in_data = '0;
  logic [LW-1:0]   lat_cfg = '0;
  logic in_accept, iss_valid;
  logic [ID_W-1:0] iss_id;
  logic [DW-1:0]   iss_data;

  always #2 clk = ~clk;

  replay_issue_queue #(.DEPTH(DEPTH), .ID_W(ID_W), .DATA_W(DW), .LAT_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_id(in_id), .in_data(in_data),
    .in_accept(in_accept), .lat_cfg(lat_cfg), .ecc_hold(ecc_hold), .iss_valid(iss_valid),
    .iss_id(iss_id), .iss_data(iss_data), .exec_done(exec_done), .exec_replay(exec_replay));

  int checks = 0, fails = 0;
  // Bench-side model state
  int cyc = 0, wr_b = 0, rd_b = 0, sav_b = 0, ready_c = 0, seq = 0, acc_cnt = 0;
  logic [ID_W-1:0] e_id  [MEMN];
  logic [DW-1:0]   e_dat [MEMN];
  string cur_tag = "R4";
  // Stimulus for the next cycle
  bit v_in = 0, v_hold = 0, v_done = 0, v_replay = 0;
  int v_lat = 1;

  function automatic logic [DW-1:0] data_of(input int s);
    return DW'(s * 37 + 11);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic tick();
    bit exp_acc, exp_iss, ret;
    int gap;
    @(negedge clk);
    in_valid = v_in; in_id = ID_W'(seq); in_data = data_of(seq);
    ecc_hold = v_hold; exec_done = v_done; exec_replay = v_replay; lat_cfg = LW'(v_lat);
    #1;
    exp_acc = (wr_b - sav_b) < DEPTH;
    check(in_accept == exp_acc, "R2 accept", int'(in_accept), int'(exp_acc));
    exp_iss = (cyc >= ready_c) && (wr_b > rd_b) && !v_replay;
    check(iss_valid == exp_iss, {cur_tag, " iss_valid"}, int'(iss_valid), int'(exp_iss));
    if (exp_iss && iss_valid) begin
      check(iss_id == e_id[rd_b % MEMN], "R3 id", int'(iss_id), int'(e_id[rd_b % MEMN]));
      check(iss_data == e_dat[rd_b % MEMN], "R3 data", int'(iss_data), int'(e_dat[rd_b % MEMN]));
    end
    if (v_in && in_accept) acc_cnt++;
    ret = v_done && (rd_b > sav_b);
    gap = (v_lat == 0) ? 1 : v_lat;
    if (exp_iss) begin rd_b++; ready_c = cyc + gap; end
    else if (!v_replay && v_hold && cyc < ready_c) ready_c++;
    if (v_in && exp_acc) begin
      e_id[wr_b % MEMN] = ID_W'(seq); e_dat[wr_b % MEMN] = data_of(seq);
      wr_b++; seq++;
    end
    if (ret) sav_b++;
    if (v_replay) begin rd_b = sav_b; ready_c = cyc + 1; end
    cyc++;
  endtask

  task automatic drain(input int n);
    v_in = 0; v_hold = 0; v_replay = 0; v_done = 1;
    repeat (n) tick();
    v_done = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int t1, t2, base, got, issued;
    bit rp_done, after_rp;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(in_accept == 1'b1, "R1 accept after reset", int'(in_accept), 1);
    check(iss_valid == 1'b0, "R1 no issue after reset", int'(iss_valid), 0);

    // R4: latency sweep over every setting
    cur_tag = "R4";
    for (int L = 0; L < 16; L++) begin
      v_lat = L; v_done = 1; t1 = -1; t2 = -1;
      for (int n = 0; n < 5 * ((L == 0) ? 1 : L) + 8; n++) begin
        v_in = (n < 5);
        tick();
        if (iss_valid) begin
          if (t1 < 0) t1 = cyc - 1; else if (t2 < 0) t2 = cyc - 1;
        end
      end
      check(t2 - t1 == ((L == 0) ? 1 : L), "R4 spacing", t2 - t1, (L == 0) ? 1 : L);
      drain(4);
    end

    // R8 / R7: fill with no completions, then ignored completions
    cur_tag = "R8"; v_lat = 1; v_done = 0; acc_cnt = 0;
    v_in = 1; repeat (14) tick();
    check(acc_cnt == DEPTH, "R2 accepted count when full", acc_cnt, DEPTH);
    check(in_accept == 1'b0, "R8 full with all issued", int'(in_accept), 0);
    check(iss_valid == 1'b0, "R9 nothing left to issue", int'(iss_valid), 0);
    drain(DEPTH + 3);
    cur_tag = "R7"; v_done = 1; repeat (3) tick(); v_done = 0;
    acc_cnt = 0; v_in = 1; repeat (12) tick();
    check(acc_cnt == DEPTH, "R7 idle completions ignored", acc_cnt, DEPTH);
    drain(DEPTH + 4);

    // R5: hold at each offset inside a countdown of 4
    cur_tag = "R5";
    for (int k = 1; k <= 4; k++) begin
      t1 = -1; t2 = -1; v_lat = 4; v_done = 1;
      for (int n = 0; n < 16; n++) begin
        v_in = (n < 2);
        v_hold = (t1 >= 0) && (cyc == t1 + k);
        tick();
        if (iss_valid) begin
          if (t1 < 0) t1 = cyc - 1; else if (t2 < 0) t2 = cyc - 1;
        end
      end
      check(t2 - t1 == ((k < 4) ? 5 : 4), "R5 hold stretch", t2 - t1, (k < 4) ? 5 : 4);
      v_hold = 0; drain(4);
    end

    // R6: replay after three unconfirmed issues
    cur_tag = "R6"; base = seq; issued = 0; got = -1; rp_done = 0; after_rp = 0;
    v_lat = 2; v_done = 0;
    for (int n = 0; n < 40; n++) begin
      v_in = (n < 6);
      v_replay = (issued == 3) && !rp_done;
      v_done = (n >= 24);
      tick();
      if (after_rp) begin
        check(iss_valid == 1'b1, "R6 reissue next cycle", int'(iss_valid), 1);
        after_rp = 0;
      end
      if (v_replay) begin rp_done = 1; after_rp = 1; end
      if (iss_valid) begin
        if (!rp_done) issued++;
        else if (got < 0) got = int'(iss_id);
      end
    end
    v_replay = 0;
    check(got == (base % 16), "R6 restart at oldest", got, base % 16);
    drain(20);

    // Mixed pseudo-random phase
    cur_tag = "R9"; lfsr = 16'hACE1;
    for (int n = 0; n < 4000; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      v_in = lfsr[0] | lfsr[5];
      v_hold = lfsr[1] & lfsr[7];
      v_done = lfsr[2] | lfsr[9];
      v_replay = (lfsr[6:3] == 4'd0);
      v_lat = (lfsr[11] & lfsr[12]) ? int'(lfsr[15:13]) : int'(lfsr[14]);
      tick();
    end
    drain(200);
    check(iss_valid == 1'b0, "R9 idle after drain", int'(iss_valid), 0);
    check(in_accept == 1'b1, "R7 all retired", int'(in_accept), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule